// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This block performs packed integer addition and subtraction on a 32-bit word. The word is treated either as four independent 8-bit lanes or as two independent 16-bit lanes. Each operation picks one of three arithmetic kinds: wrap-around, clamp to range, or halve the exact result. Each kind can be signed or unsigned. Two cross forms swap the halfwords of the second operand and then add in one halfword lane while subtracting in the other.

Wrap-around operations also produce one greater-or-equal flag per byte position. These flags are held in a register. A byte-select operation then uses the held flags to build a result from bytes of the two operands. A typical sequence is a wrap-around subtract followed by a select, which gives a per-lane maximum or minimum. Every operation is registered, so the result and the flags appear one clock after the operation is presented.

Top module: `simd_addsub_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result` and `ge_flags` are cleared to 0.
- R2: With `lane_sel`=0 and `opcode` 0 (add) or 1 (subtract), the unit runs four independent byte lanes. Byte i occupies bits 8i+7:8i. With `kind`=0 (wrap) each lane result is taken modulo 2^8.
- R3: With `lane_sel`=1 and `opcode` 0 or 1, the unit runs two independent 16-bit lanes (bits 31:16 and 15:0). With `kind`=0 each lane result is taken modulo 2^16.
- R4: With `kind`=1 (clamp), each lane result is limited to the lane range. The signed range is -2^(w-1) to 2^(w-1)-1 and the unsigned range is 0 to 2^w-1, selected by `is_signed`.
- R5: With `kind`=2 (halve), each lane returns its exact (w+1)-bit sum or difference shifted right by one. The shift is arithmetic when `is_signed`=1 and logical otherwise.
- R6: `opcode` 2 gives upper = a[31:16] + b[15:0] and lower = a[15:0] - b[31:16]. `opcode` 3 gives upper = a[31:16] - b[15:0] and lower = a[15:0] + b[31:16]. Both always use 16-bit lanes, whatever the value of `lane_sel`.
- R7: A wrap-around (`kind`=0) add, subtract or cross operation loads `ge_flags`. A lane's bit is 1 when the exact signed result is at least 0 (signed), when an unsigned add carries out, or when an unsigned subtract does not borrow. For 16-bit lanes the flag is copied into both byte bits of that lane.
- R8: Clamping, halving and select operations leave `ge_flags` unchanged.
- R9: `opcode` 4 (select) sets byte i of `result` to byte i of `op_a` when `ge_flags[i]` is 1, and to byte i of `op_b` otherwise, using the flags held before the operation.
- R10: `result` and `ge_flags` update only on an edge where `in_valid` is 1, one cycle after the inputs are presented. Otherwise both hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| opcode | input | 3 | 0 add, 1 subtract, 2 cross add-high/sub-low, 3 cross sub-high/add-low, 4 select; 5-7 act as add |
| kind | input | 2 | 0 wrap, 1 clamp, 2 halve; 3 acts as wrap |
| is_signed | input | 1 | Signed lane interpretation when 1 |
| lane_sel | input | 1 | 0 four byte lanes, 1 two halfword lanes |
| result | output | 32 | Registered packed result |
| ge_flags | output | 4 | Registered per-byte greater-or-equal flags |

## Verification
The properties assume that the operation fields are meaningful only while `in_valid` is high. They also assume that `kind` and `opcode` stay within the defined encodings whenever an operation is checked for its kind-specific behaviour. The stimulus keeps to the defined codes 0-4 for `opcode` and 0-2 for `kind`, and it leaves idle cycles with `in_valid` low so that the hold behaviour is exercised. The operands include lane extremes (0x7F/0x80, 0x7FFF/0x8000, all ones, zero) next to uniformly drawn words. This makes every clamp, carry and borrow boundary appear in both lane widths.

// File: rtl/simd_pkg.sv
// Shared encodings for the packed add/subtract unit.
// Assumes the 3-bit operation and 2-bit kind fields described in the brief.
package simd_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_XAS = 3'd2,   // swap b halves, add high, subtract low
        OP_XSA = 3'd3,   // swap b halves, subtract high, add low
        OP_SEL = 3'd4
    } simd_op_e;

    typedef enum logic [1:0] {
        K_WRAP  = 2'd0,
        K_CLAMP = 2'd1,
        K_HALVE = 2'd2,
        K_RSVD  = 2'd3
    } simd_kind_e;
endpackage

// File: rtl/simd_lane.sv
// One arithmetic lane of width W.
// Forms the exact (W+1)-bit sum or difference, then wraps, clamps or halves it,
// and derives the lane's greater-or-equal flag from the exact result.
// Assumes kind values outside clamp/halve mean wrap.
module simd_lane
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    input  logic         is_signed,
    input  logic [1:0]   kind,
    output logic [W-1:0] res,
    output logic         ge
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] S_MAX    = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN    = {1'b1, {(W-1){1'b0}}};

    logic [W:0] ext_a;
    logic [W:0] ext_b;
    logic [W:0] exact;
    logic       s_ovf;

    // Extend operands by one bit and form the exact lane result.
    always_comb begin
        ext_a = {is_signed & a[W-1], a};
        ext_b = {is_signed & b[W-1], b};
        exact = do_sub ? (ext_a - ext_b) : (ext_a + ext_b);
        s_ovf = exact[W] ^ exact[W-1];
    end

    // Pick the lane result for the requested arithmetic kind.
    always_comb begin
        unique case (kind)
            K_CLAMP: begin
                if (is_signed)
                    res = s_ovf ? (exact[W] ? S_MIN : S_MAX) : exact[W-1:0];
                else if (exact[W])
                    res = do_sub ? '0 : ALL_ONES;
                else
                    res = exact[W-1:0];
            end
            K_HALVE: res = exact[W:1];
            default: res = exact[W-1:0];
        endcase
    end

    // Greater-or-equal: non-negative signed, carry on add, no borrow on subtract.
    always_comb begin
        if (is_signed || do_sub)
            ge = ~exact[W];
        else
            ge = exact[W];
    end
endmodule

// File: rtl/simd_byte_sel.sv
// Byte-wise two-way selector: byte i comes from a when mask[i] is set, else from b.
// Assumes the data width is a whole number of bytes.
module simd_byte_sel #(
    parameter int NBYTE  = 4,
    parameter int BYTE_W = 8
) (
    input  logic [NBYTE*BYTE_W-1:0] a,
    input  logic [NBYTE*BYTE_W-1:0] b,
    input  logic [NBYTE-1:0]        mask,
    output logic [NBYTE*BYTE_W-1:0] y
);
    for (genvar i = 0; i < NBYTE; i++) begin : g_byte
        // Choose one byte under its mask bit.
        always_comb begin
            y[i*BYTE_W +: BYTE_W] = mask[i] ? a[i*BYTE_W +: BYTE_W]
                                            : b[i*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/simd_addsub_unit.sv
// Packed add/subtract unit with registered result and greater-or-equal flags.
// Runs byte or halfword lanes in wrap, clamp or halve arithmetic, cross forms on
// swapped halves, and a flag-driven byte select. One cycle of latency.
// Assumes the cross forms pair halfword lanes two at a time (upper/lower).
module simd_addsub_unit
    import simd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [2:0]        opcode,
    input  logic [1:0]        kind,
    input  logic              is_signed,
    input  logic              lane_sel,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W/BYTE_W-1:0] ge_flags
);
    localparam int NBYTE  = DATA_W / BYTE_W;
    localparam int NHALF  = DATA_W / HALF_W;
    localparam int BPH    = HALF_W / BYTE_W;

    simd_op_e          op;
    logic              is_cross;
    logic              use_half;
    logic              is_sel;
    logic [DATA_W-1:0] byte_res;
    logic [NBYTE-1:0]  byte_ge;
    logic [DATA_W-1:0] half_res;
    logic [NHALF-1:0]  half_ge;
    logic [NBYTE-1:0]  half_ge_wide;
    logic [DATA_W-1:0] sel_res;
    logic [DATA_W-1:0] res_d;
    logic [NBYTE-1:0]  ge_d;
    logic              flag_load;

    // Decode the operation into lane width and datapath choice.
    always_comb begin
        op       = simd_op_e'(opcode);
        is_cross = (op == OP_XAS) || (op == OP_XSA);
        is_sel   = (op == OP_SEL);
        use_half = lane_sel || is_cross;
    end

    // Byte lanes: plain add or subtract.
    for (genvar i = 0; i < NBYTE; i++) begin : g_blane
        simd_lane #(.W(BYTE_W)) u_lane (
            .a        (op_a[i*BYTE_W +: BYTE_W]),
            .b        (op_b[i*BYTE_W +: BYTE_W]),
            .do_sub   (op == OP_SUB),
            .is_signed(is_signed),
            .kind     (kind),
            .res      (byte_res[i*BYTE_W +: BYTE_W]),
            .ge       (byte_ge[i])
        );
    end

    // Halfword lanes: cross forms read the partner half of b and alternate add/sub.
    for (genvar h = 0; h < NHALF; h++) begin : g_hlane
        localparam int PARTNER = h ^ 1;
        logic [HALF_W-1:0] b_pick;
        logic              sub_h;

        // Choose the b half and the direction for this halfword lane.
        always_comb begin
            b_pick = is_cross ? op_b[PARTNER*HALF_W +: HALF_W] : op_b[h*HALF_W +: HALF_W];
            unique case (op)
                OP_SUB:  sub_h = 1'b1;
                OP_XAS:  sub_h = ((h % 2) == 0);
                OP_XSA:  sub_h = ((h % 2) == 1);
                default: sub_h = 1'b0;
            endcase
        end

        simd_lane #(.W(HALF_W)) u_lane (
            .a        (op_a[h*HALF_W +: HALF_W]),
            .b        (b_pick),
            .do_sub   (sub_h),
            .is_signed(is_signed),
            .kind     (kind),
            .res      (half_res[h*HALF_W +: HALF_W]),
            .ge       (half_ge[h])
        );

        // Copy the halfword flag into every byte bit of the lane.
        always_comb begin
            half_ge_wide[h*BPH +: BPH] = {BPH{half_ge[h]}};
        end
    end

    simd_byte_sel #(.NBYTE(NBYTE), .BYTE_W(BYTE_W)) u_sel (
        .a   (op_a),
        .b   (op_b),
        .mask(ge_flags),
        .y   (sel_res)
    );

    // Form the next result, next flags and the flag-load condition.
    always_comb begin
        if (is_sel)
            res_d = sel_res;
        else if (use_half)
            res_d = half_res;
        else
            res_d = byte_res;
        ge_d      = use_half ? half_ge_wide : byte_ge;
        flag_load = in_valid && !is_sel &&
                    ((kind == K_WRAP) || (kind == K_RSVD));
    end

    // Result register: loads on every accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (in_valid)
            result <= res_d;
    end

    // Flag register: loads only on wrap-around arithmetic.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ge_flags <= '0;
        else if (flag_load)
            ge_flags <= ge_d;
    end
endmodule

// File: rtl/simd_addsub_chk.sv
// Property checker for simd_addsub_unit, bound to every instance.
// Assumes the default 32-bit width with byte and halfword lanes.
module simd_addsub_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic [2:0]  opcode,
    input logic [1:0]  kind,
    input logic        is_signed,
    input logic        lane_sel,
    input logic [31:0] result,
    input logic [3:0]  ge_flags
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (result == 32'h0) && (ge_flags == 4'h0));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(ge_flags));

    assert_flags_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (kind == 2'd1 || kind == 2'd2 || opcode == 3'd4) |=> $stable(ge_flags));

    assert_usat_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && opcode == 3'd0 && kind == 2'd1 && !is_signed && !lane_sel
        |=> (result[7:0] >= $past(op_a[7:0])) && (result[7:0] >= $past(op_b[7:0])));

    assert_uhalf_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && opcode == 3'd0 && kind == 2'd2 && !is_signed && !lane_sel
        |=> ((result[7:0] >= $past(op_a[7:0])) || (result[7:0] >= $past(op_b[7:0])))
         && ((result[7:0] <= $past(op_a[7:0])) || (result[7:0] <= $past(op_b[7:0]))));

    assert_cross_ge_pairs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (opcode == 3'd2 || opcode == 3'd3) && kind == 2'd0
        |=> (ge_flags[1] == ge_flags[0]) && (ge_flags[3] == ge_flags[2]));

    assert_sel_low_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && opcode == 3'd4
        |=> result[7:0] == ($past(ge_flags[0]) ? $past(op_a[7:0]) : $past(op_b[7:0])));
endmodule

bind simd_addsub_unit simd_addsub_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .opcode   (opcode),
    .kind     (kind),
    .is_signed(is_signed),
    .lane_sel (lane_sel),
    .result   (result),
    .ge_flags (ge_flags)
);

// File: tb/sim_simd_addsub_unit.sv
module sim_simd_addsub_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [2:0]  opcode = '0;
    logic [1:0]  kind = '0;
    logic        is_signed = 1'b0;
    logic        lane_sel = 1'b0;
    logic [31:0] result;
    logic [3:0]  ge_flags;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state
    logic [31:0] m_res = '0;
    logic [3:0]  m_ge = '0;

    always #5 clk = ~clk;

    simd_addsub_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .opcode(opcode), .kind(kind), .is_signed(is_signed), .lane_sel(lane_sel),
        .result(result), .ge_flags(ge_flags)
    );

    // One lane of the reference: exact integer arithmetic, then the kind.
    function automatic void lane_ref(input int w, input longint a, input longint b,
                                     input bit sub, input bit sgn, input int k,
                                     output longint r, output bit g);
        longint m, av, bv, s, lo, hi;
        m  = longint'(1) << w;
        av = a; bv = b;
        if (sgn && av >= m / 2) av = av - m;
        if (sgn && bv >= m / 2) bv = bv - m;
        s = sub ? av - bv : av + bv;
        if (sgn)      g = (s >= 0);
        else if (sub) g = (s >= 0);
        else          g = (s >= m);
        lo = sgn ? -(m / 2) : 0;
        hi = sgn ? (m / 2 - 1) : (m - 1);
        if (k == 1) begin
            if (s < lo) s = lo;
            if (s > hi) s = hi;
        end else if (k == 2) begin
            s = s >>> 1;
        end
        r = s & (m - 1);
    endfunction

    // Whole-word reference step applied to the model state.
    task automatic model_step(input logic [31:0] a, input logic [31:0] b, input int op,
                              input int k, input bit sgn, input bit half);
        logic [31:0] nr;
        logic [3:0]  ng;
        longint r;
        bit g;
        nr = '0; ng = '0;
        if (op == 4) begin
            for (int i = 0; i < 4; i++)
                nr[i*8 +: 8] = m_ge[i] ? a[i*8 +: 8] : b[i*8 +: 8];
        end else if (half || op == 2 || op == 3) begin
            for (int i = 0; i < 2; i++) begin
                bit sub;
                logic [15:0] bh;
                sub = (op == 1) || (op == 2 && i == 0) || (op == 3 && i == 1);
                bh  = (op == 2 || op == 3) ? b[(1-i)*16 +: 16] : b[i*16 +: 16];
                lane_ref(16, longint'(a[i*16 +: 16]), longint'(bh), sub, sgn, k, r, g);
                nr[i*16 +: 16] = r[15:0];
                ng[i*2 +: 2] = {g, g};
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                lane_ref(8, longint'(a[i*8 +: 8]), longint'(b[i*8 +: 8]), (op == 1), sgn, k, r, g);
                nr[i*8 +: 8] = r[7:0];
                ng[i] = g;
            end
        end
        m_res = nr;
        if (op != 4 && k == 0) m_ge = ng;
    endtask

    task automatic check(input string tag_r, input string tag_g);
        checks++;
        if (result !== m_res) begin
            failures++;
            $display("FAIL %s result actual=%h expected=%h", tag_r, result, m_res);
        end
        checks++;
        if (ge_flags !== m_ge) begin
            failures++;
            $display("FAIL %s ge_flags actual=%b expected=%b", tag_g, ge_flags, m_ge);
        end
    endtask

    // Present one operation, advance the model, compare after the edge.
    task automatic do_op(input logic [31:0] a, input logic [31:0] b, input int op,
                         input int k, input bit sgn, input bit half);
        string tr, tg;
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; opcode = 3'(op); kind = 2'(k);
        is_signed = sgn; lane_sel = half;
        if (op == 4)                tr = "R9";
        else if (op == 2 || op == 3) tr = "R6";
        else if (k == 1)            tr = "R4";
        else if (k == 2)            tr = "R5";
        else if (half)              tr = "R3";
        else                        tr = "R2";
        tg = (op != 4 && k == 0) ? "R7" : "R8";
        model_step(a, b, op, k, sgn, half);
        @(posedge clk); #2;
        check(tr, tg);
    endtask

    // Idle cycle with garbage on the operand pins: nothing may change.
    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0; op_a = $urandom; op_b = $urandom; opcode = 3'd1; kind = 2'd0;
        @(posedge clk); #2;
        check("R10", "R10");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(posedge clk); #2;
        m_res = '0; m_ge = '0;
        check("R1", "R1");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] pick_word();
        int sel;
        sel = $urandom_range(0, 7);
        case (sel)
            0: return 32'h7F7F_7FFF;
            1: return 32'h8080_8000;
            2: return 32'hFFFF_FFFF;
            3: return 32'h0000_0000;
            4: return 32'h0180_7F01;
            default: return $urandom;
        endcase
    endfunction

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        do_reset();
        // R2: byte wrap, carries and borrows at the lane edge
        do_op(32'hFF80_7F01, 32'h0180_0101, 0, 0, 0, 0);
        do_op(32'h0000_1080, 32'h0101_2001, 1, 0, 1, 0);
        // R3: halfword wrap
        do_op(32'hFFFF_7FFF, 32'h0001_0001, 0, 0, 1, 1);
        do_op(32'h0000_8000, 32'h0001_0001, 1, 0, 0, 1);
        // R4: clamp at every bound, and R8 flags kept across it
        do_op(32'h7F80_FF00, 32'h0101_0101, 0, 1, 1, 0);
        do_op(32'h807F_00FF, 32'h0181_0101, 1, 1, 1, 0);
        do_op(32'hFF00_F0FF, 32'h0101_20FF, 0, 1, 0, 0);
        do_op(32'h0000_1000, 32'h0001_2000, 1, 1, 0, 1);
        do_op(32'h7FFF_8000, 32'h0001_0001, 0, 1, 1, 1);
        // R5: halving signed/unsigned
        do_op(32'hFF80_7F01, 32'hFF80_7F02, 0, 2, 0, 0);
        do_op(32'h8000_7FFF, 32'h8000_7FFF, 0, 2, 1, 1);
        do_op(32'h0000_0003, 32'h0001_0000, 1, 2, 1, 0);
        // R6: cross forms, including lane_sel=0
        do_op(32'h1000_0005, 32'h0003_0020, 2, 0, 0, 0);
        do_op(32'h1000_0005, 32'h0003_0020, 3, 0, 1, 1);
        do_op(32'h7FFF_8000, 32'h0001_0001, 2, 1, 1, 1);
        // R7 then R9: flags from a compare, select for max/min
        do_op(32'h1020_3040, 32'h4030_2010, 1, 0, 0, 0);
        do_op(32'h1020_3040, 32'h4030_2010, 4, 0, 0, 0);
        do_op(32'h8000_0010, 32'h0001_0020, 1, 0, 1, 1);
        do_op(32'hAAAA_BBBB, 32'h1111_2222, 4, 1, 0, 0);
        // R10: idle cycles hold everything
        idle_cycle();
        idle_cycle();
        // Broad coverage of all combinations
        for (int n = 0; n < 600; n++) begin
            if (n % 37 == 5) idle_cycle();
            do_op(pick_word(), pick_word(), $urandom_range(0, 4), $urandom_range(0, 2),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        // R1: reset in mid-run clears state
        do_op(32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0, 0);
        do_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule